// File: doc/BRIEF.md
# Exception Entry Vectoring Unit

This block performs exception entry for a small in-order processor. It takes one exception request with a cause code and an error code. With the request it takes the current program counter, the current machine-state word, a vector prefix and two banks of vector offsets. From these it works out the vector index and which save/restore register pair receives the context. It then writes the return address and the saved state word into that pair, builds the state word the handler will run with, and forms the handler address.

The pipeline control logic presents a request for one cycle. One cycle later the unit answers with a completion pulse, the handler PC, the new state word and write strobes for the save pairs, and the three save pairs hold their new contents. A cause that does not resolve to a legal vector index raises a sticky error instead of vectoring. While that error stands, further requests are refused until the control logic clears it.

Top module: `exc_entry_unit`

## Requirements
- R1: Cause code N (6 bits) for N in 0..14 maps to vector index N (0 reset, 1 machine check, 2 data storage, 3 instruction storage, 4 external, 5 alignment, 6 program, 7 FP-unavailable, 8 system call, 9 auxiliary-unit-unavailable, 10 fixed-interval timer, 11 programmable-interval timer, 12 watchdog, 13 data TLB miss, 14 instruction TLB miss). The handler PC is the prefix ORed with entry `idx` of the low offset bank (entry k at bits k*64 of `off_lo_i`).
- R2: For a program exception, the subcause is `err_code_i[1:0]` (0 FP-enabled, 1 illegal, 2 privileged, 3 trap). A trap uses vector index 15. The saved state gets bit 20, 19, 18 or 17 set for subcause 0, 1, 2 or 3 respectively; 3 gives 0x00020000.
- R3: Cause codes 32..37 use vector index 32..37. The offset comes from entry idx-32 of the high bank.
- R4: Any other cause (15 debug, 16 decrementer, 17..31, 38..63) has an unassigned or illegal index. It sets `err_o` on the next cycle, with no completion pulse and no save write. `err_o` stays set until `err_clr_i` is sampled high.
- R5: A request sampled while `err_o` is high is ignored: no completion, no save write, and the save pairs are unchanged.
- R6: Reset (0) and watchdog (12) write the critical pair. All other legal causes except machine check write the standard pair.
- R7: Machine check writes the machine-check pair and copies the same address and state into the critical pair. It clears critical-enable (bit 17) and machine-check-enable (bit 12) in the new state.
- R8: Alignment, program and FP-unavailable save PC-4. All other causes save the PC.
- R9: Data storage, instruction storage, program, FP-unavailable and the three timer causes (10, 11, 12) clear bits 31:16 of the saved state. Instruction storage then ORs in `err_code_i`. Other causes save the state unchanged.
- R10: The new state is the current state with bits 5 (instruction translation), 4 (data translation), 1 (recoverable) and 18 (power save) cleared. Bit 0 (little-endian) takes bit 16, and bit 31 (computation mode) takes bit 30.
- R11: When the new bit 31 is 0, the prefix is truncated to its low 32 bits before the OR. When it is 1, all 64 bits are used.
- R12: An accepted legal request gives `done_o` and the write strobes for exactly one cycle, one clock after the request. Reset clears all save registers, the new state, the new PC, `done_o` and `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Exception request, sampled each edge |
| cause_i | input | 6 | Cause code |
| err_code_i | input | SW | Error code / program subcause |
| pc_i | input | XLEN | PC of the next instruction |
| state_i | input | SW | Current machine-state word |
| vec_prefix_i | input | XLEN | Vector prefix |
| off_lo_i | input | N_LO*XLEN | Low offset bank, flattened |
| off_hi_i | input | N_HI*XLEN | High offset bank, flattened |
| err_clr_i | input | 1 | Clears the pending error |
| done_o | output | 1 | Entry completed pulse |
| new_pc_o | output | XLEN | Handler address |
| new_state_o | output | SW | Handler state word |
| std_we_o | output | 1 | Standard pair written |
| std_addr_o | output | XLEN | Standard pair return address |
| std_state_o | output | SW | Standard pair saved state |
| crit_we_o | output | 1 | Critical pair written |
| crit_addr_o | output | XLEN | Critical pair return address |
| crit_state_o | output | SW | Critical pair saved state |
| mc_we_o | output | 1 | Machine-check pair written |
| mc_addr_o | output | XLEN | Machine-check pair return address |
| mc_state_o | output | SW | Machine-check pair saved state |
| err_o | output | 1 | Illegal-index error pending |

## Verification
The hardest cases to reach are the ones where the cause code alone does not decide the result. A program trap reaches index 15 through the subcause, while debug cause 15 itself is illegal. A request that arrives while an error is pending must leave every save pair untouched. The stimulus sweeps all 64 cause codes against all four subcauses and two state patterns, one with the computation-mode source bit set and one with it clear. After each illegal cause it issues a legal request while the error is still held. It then compares every save pair with a reference model before and after clearing the error.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int CAUSE_W = 6;
  localparam int IDX_W   = 6;
  localparam int HI_BASE = 32;

  localparam logic [CAUSE_W-1:0] C_RESET = 6'd0;
  localparam logic [CAUSE_W-1:0] C_MCHK  = 6'd1;
  localparam logic [CAUSE_W-1:0] C_DSTOR = 6'd2;
  localparam logic [CAUSE_W-1:0] C_ISTOR = 6'd3;
  localparam logic [CAUSE_W-1:0] C_ALIGN = 6'd5;
  localparam logic [CAUSE_W-1:0] C_PROG  = 6'd6;
  localparam logic [CAUSE_W-1:0] C_FPU   = 6'd7;
  localparam logic [CAUSE_W-1:0] C_FIT   = 6'd10;
  localparam logic [CAUSE_W-1:0] C_PIT   = 6'd11;
  localparam logic [CAUSE_W-1:0] C_WDOG  = 6'd12;
  localparam logic [CAUSE_W-1:0] C_LAST  = 6'd14;
  localparam logic [CAUSE_W-1:0] C_DEBUG = 6'd15;
  localparam logic [1:0]         SUB_TRAP = 2'd3;
  localparam logic [IDX_W-1:0]   IDX_TRAP = 6'd15;

  // state word bit positions
  localparam int ST_LE  = 0;
  localparam int ST_RI  = 1;
  localparam int ST_DR  = 4;
  localparam int ST_IR  = 5;
  localparam int ST_ME  = 12;
  localparam int ST_ILE = 16;
  localparam int ST_CE  = 17;
  localparam int ST_POW = 18;
  localparam int ST_ICM = 30;
  localparam int ST_CM  = 31;

  typedef enum logic [1:0] {PAIR_STD, PAIR_CRIT, PAIR_MC} pair_e;
  typedef enum logic [1:0] {SM_KEEP, SM_CLR, SM_CLR_ERR, SM_PROG} smask_e;

  typedef struct packed {
    logic             legal;
    logic [IDX_W-1:0] idx;
    pair_e            pair;
    logic             save_cur;
    smask_e           smask;
  } cls_t;
endpackage

// File: rtl/exc_classify.sv
module exc_classify
  import exc_pkg::*;
#(
  parameter int N_HI = 6
) (
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [1:0]         sub_i,
  output cls_t               cls_o
);
  logic mapped;

  assign mapped = (cause_i <= C_LAST) ||
                  ((int'(cause_i) >= HI_BASE) && (int'(cause_i) < HI_BASE + N_HI));

  always_comb begin
    cls_o          = '0;
    cls_o.idx      = cause_i;
    cls_o.pair     = PAIR_STD;
    cls_o.smask    = SM_KEEP;
    cls_o.save_cur = 1'b0;
    case (cause_i)
      C_RESET: cls_o.pair = PAIR_CRIT;
      C_MCHK:  cls_o.pair = PAIR_MC;
      C_DSTOR: cls_o.smask = SM_CLR;
      C_ISTOR: cls_o.smask = SM_CLR_ERR;
      C_ALIGN: cls_o.save_cur = 1'b1;
      C_PROG: begin
        cls_o.save_cur = 1'b1;
        cls_o.smask    = SM_PROG;
        if (sub_i == SUB_TRAP) cls_o.idx = IDX_TRAP;
      end
      C_FPU: begin
        cls_o.save_cur = 1'b1;
        cls_o.smask    = SM_CLR;
      end
      C_FIT, C_PIT: cls_o.smask = SM_CLR;
      C_WDOG: begin
        cls_o.smask = SM_CLR;
        cls_o.pair  = PAIR_CRIT;
      end
      C_DEBUG: cls_o.pair = PAIR_CRIT;  // index unassigned: never completes
      default: ;
    endcase
    cls_o.legal = mapped;
  end
endmodule

// File: rtl/exc_vector.sv
module exc_vector
  import exc_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int N_LO = 16,
  parameter int N_HI = 6
) (
  input  logic [XLEN-1:0]      prefix_i,
  input  logic [N_LO*XLEN-1:0] off_lo_i,
  input  logic [N_HI*XLEN-1:0] off_hi_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic                 cm_i,
  output logic [XLEN-1:0]      handler_o
);
  logic [XLEN-1:0] lo_arr [N_LO];
  logic [XLEN-1:0] hi_arr [N_HI];
  logic [XLEN-1:0] off_sel;
  logic [XLEN-1:0] pfx_eff;

  for (genvar g = 0; g < N_LO; g++) begin : g_lo
    assign lo_arr[g] = off_lo_i[g*XLEN +: XLEN];
  end
  for (genvar g = 0; g < N_HI; g++) begin : g_hi
    assign hi_arr[g] = off_hi_i[g*XLEN +: XLEN];
  end

  always_comb begin
    off_sel = '0;
    for (int i = 0; i < N_LO; i++)
      if (idx_i == IDX_W'(i)) off_sel = lo_arr[i];
    for (int i = 0; i < N_HI; i++)
      if (idx_i == IDX_W'(HI_BASE + i)) off_sel = hi_arr[i];
  end

  assign pfx_eff   = cm_i ? prefix_i : {{(XLEN-32){1'b0}}, prefix_i[31:0]};
  assign handler_o = pfx_eff | off_sel;
endmodule

// File: rtl/exc_ctx_build.sv
module exc_ctx_build
  import exc_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int SW   = 32
) (
  input  cls_t            cls_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [SW-1:0]   state_i,
  input  logic [SW-1:0]   err_i,
  output logic [XLEN-1:0] ret_o,
  output logic [SW-1:0]   saved_o,
  output logic [SW-1:0]   new_o
);
  localparam logic [SW-1:0] HI_MASK = SW'(32'hFFFF_0000);

  logic [SW-1:0] cleared;
  logic [SW-1:0] prog_bit;

  assign ret_o    = cls_i.save_cur ? pc_i - XLEN'(4) : pc_i;
  assign cleared  = state_i & ~HI_MASK;
  assign prog_bit = SW'(1) << (5'd20 - {3'd0, err_i[1:0]});

  always_comb begin
    case (cls_i.smask)
      SM_CLR:     saved_o = cleared;
      SM_CLR_ERR: saved_o = cleared | err_i;
      SM_PROG:    saved_o = cleared | prog_bit;
      default:    saved_o = state_i;
    endcase
  end

  always_comb begin
    new_o         = state_i;
    new_o[ST_IR]  = 1'b0;
    new_o[ST_DR]  = 1'b0;
    new_o[ST_RI]  = 1'b0;
    new_o[ST_POW] = 1'b0;
    new_o[ST_LE]  = state_i[ST_ILE];
    new_o[ST_CM]  = state_i[ST_ICM];
    if (cls_i.pair == PAIR_MC) begin
      new_o[ST_CE] = 1'b0;
      new_o[ST_ME] = 1'b0;
    end
  end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int SW   = 32,
  parameter int N_LO = 16,
  parameter int N_HI = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic [CAUSE_W-1:0]   cause_i,
  input  logic [SW-1:0]        err_code_i,
  input  logic [XLEN-1:0]      pc_i,
  input  logic [SW-1:0]        state_i,
  input  logic [XLEN-1:0]      vec_prefix_i,
  input  logic [N_LO*XLEN-1:0] off_lo_i,
  input  logic [N_HI*XLEN-1:0] off_hi_i,
  input  logic                 err_clr_i,
  output logic                 done_o,
  output logic [XLEN-1:0]      new_pc_o,
  output logic [SW-1:0]        new_state_o,
  output logic                 std_we_o,
  output logic [XLEN-1:0]      std_addr_o,
  output logic [SW-1:0]        std_state_o,
  output logic                 crit_we_o,
  output logic [XLEN-1:0]      crit_addr_o,
  output logic [SW-1:0]        crit_state_o,
  output logic                 mc_we_o,
  output logic [XLEN-1:0]      mc_addr_o,
  output logic [SW-1:0]        mc_state_o,
  output logic                 err_o
);
  cls_t            cls;
  logic [XLEN-1:0] ret_addr, handler;
  logic [SW-1:0]   saved_st, new_st;
  logic            accept, go, bad, wr_std, wr_crit, wr_mc;

  exc_classify #(.N_HI(N_HI)) u_cls (
    .cause_i (cause_i),
    .sub_i   (err_code_i[1:0]),
    .cls_o   (cls)
  );

  exc_ctx_build #(.XLEN(XLEN), .SW(SW)) u_ctx (
    .cls_i   (cls),
    .pc_i    (pc_i),
    .state_i (state_i),
    .err_i   (err_code_i),
    .ret_o   (ret_addr),
    .saved_o (saved_st),
    .new_o   (new_st)
  );

  exc_vector #(.XLEN(XLEN), .N_LO(N_LO), .N_HI(N_HI)) u_vec (
    .prefix_i  (vec_prefix_i),
    .off_lo_i  (off_lo_i),
    .off_hi_i  (off_hi_i),
    .idx_i     (cls.idx),
    .cm_i      (new_st[ST_CM]),
    .handler_o (handler)
  );

  assign accept  = req_i & ~err_o;
  assign go      = accept & cls.legal;
  assign bad     = accept & ~cls.legal;
  assign wr_std  = go & (cls.pair == PAIR_STD);
  assign wr_mc   = go & (cls.pair == PAIR_MC);
  assign wr_crit = go & ((cls.pair == PAIR_CRIT) | (cls.pair == PAIR_MC));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o    <= 1'b0;
      std_we_o  <= 1'b0;
      crit_we_o <= 1'b0;
      mc_we_o   <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      done_o    <= go;
      std_we_o  <= wr_std;
      crit_we_o <= wr_crit;
      mc_we_o   <= wr_mc;
      if (bad)            err_o <= 1'b1;
      else if (err_clr_i) err_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      new_pc_o    <= '0;
      new_state_o <= '0;
    end else if (go) begin
      new_pc_o    <= handler;
      new_state_o <= new_st;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      std_addr_o  <= '0;
      std_state_o <= '0;
    end else if (wr_std) begin
      std_addr_o  <= ret_addr;
      std_state_o <= saved_st;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crit_addr_o  <= '0;
      crit_state_o <= '0;
    end else if (wr_crit) begin
      crit_addr_o  <= ret_addr;
      crit_state_o <= saved_st;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mc_addr_o  <= '0;
      mc_state_o <= '0;
    end else if (wr_mc) begin
      mc_addr_o  <= ret_addr;
      mc_state_o <= saved_st;
    end
  end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int SW   = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_i,
  input logic            done_o,
  input logic            err_o,
  input logic            std_we_o,
  input logic            crit_we_o,
  input logic            mc_we_o,
  input logic [XLEN-1:0] std_addr_o,
  input logic [XLEN-1:0] crit_addr_o,
  input logic [XLEN-1:0] mc_addr_o,
  input logic [SW-1:0]   crit_state_o,
  input logic [SW-1:0]   mc_state_o,
  input logic [SW-1:0]   new_state_o
);
  p_mc_copy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mc_we_o |-> crit_we_o && (crit_addr_o == mc_addr_o) && (crit_state_o == mc_state_o));

  p_mc_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mc_we_o |-> !new_state_o[ST_CE] && !new_state_o[ST_ME]);

  p_ignore_err_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !done_o);

  p_err_no_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> !done_o && !std_we_o && !crit_we_o && !mc_we_o);

  p_one_pair_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (std_we_o != crit_we_o));

  p_we_done_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (std_we_o || crit_we_o || mc_we_o) |-> done_o);

  p_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(req_i) |-> !done_o);

  p_std_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !std_we_o |-> $stable(std_addr_o));

  p_new_state_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !new_state_o[ST_IR] && !new_state_o[ST_DR] &&
               !new_state_o[ST_RI] && !new_state_o[ST_POW]);
endmodule

bind exc_entry_unit exc_entry_chk #(.XLEN(XLEN), .SW(SW)) u_chk (.*);

// File: tb/tb_exc_entry_unit.sv
module tb_exc_entry_unit;
  localparam int XLEN = 64;
  localparam int SW   = 32;
  localparam int N_LO = 16;
  localparam int N_HI = 6;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req = 1'b0, err_clr = 1'b0;
  logic [5:0] cause = '0;
  logic [SW-1:0] errc = '0, state = '0;
  logic [XLEN-1:0] pc = '0, prefix = '0;
  logic [N_LO*XLEN-1:0] off_lo;
  logic [N_HI*XLEN-1:0] off_hi;
  logic done, std_we, crit_we, mc_we, err;
  logic [XLEN-1:0] new_pc, std_a, crit_a, mc_a;
  logic [SW-1:0] new_st, std_s, crit_s, mc_s;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [XLEN-1:0] m_std_a = '0, m_crit_a = '0, m_mc_a = '0;
  logic [SW-1:0]   m_std_s = '0, m_crit_s = '0, m_mc_s = '0;

  always #2.5 clk = ~clk;

  exc_entry_unit #(.XLEN(XLEN), .SW(SW), .N_LO(N_LO), .N_HI(N_HI)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .cause_i(cause), .err_code_i(errc),
    .pc_i(pc), .state_i(state), .vec_prefix_i(prefix), .off_lo_i(off_lo),
    .off_hi_i(off_hi), .err_clr_i(err_clr), .done_o(done), .new_pc_o(new_pc),
    .new_state_o(new_st), .std_we_o(std_we), .std_addr_o(std_a), .std_state_o(std_s),
    .crit_we_o(crit_we), .crit_addr_o(crit_a), .crit_state_o(crit_s),
    .mc_we_o(mc_we), .mc_addr_o(mc_a), .mc_state_o(mc_s), .err_o(err));

  function automatic logic [XLEN-1:0] off_val(int k);
    return XLEN'(k) * 64'h20 + 64'h8;
  endfunction

  for (genvar g = 0; g < N_LO; g++) begin : g_lo
    assign off_lo[g*XLEN +: XLEN] = off_val(g);
  end
  for (genvar g = 0; g < N_HI; g++) begin : g_hi
    assign off_hi[g*XLEN +: XLEN] = off_val(100 + g);
  end

  task automatic chk(string req_tag, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", req_tag, act, exp, $time);
    end
  endtask

  task automatic chk_pairs(string tag);
    chk({tag, " R6 std addr"}, std_a, m_std_a);
    chk({tag, " R6 std state"}, XLEN'(std_s), XLEN'(m_std_s));
    chk({tag, " R7 crit addr"}, crit_a, m_crit_a);
    chk({tag, " R7 crit state"}, XLEN'(crit_s), XLEN'(m_crit_s));
    chk({tag, " R7 mc addr"}, mc_a, m_mc_a);
    chk({tag, " R7 mc state"}, XLEN'(mc_s), XLEN'(m_mc_s));
  endtask

  task automatic run_one(int c, int sub, logic [SW-1:0] st);
    bit legal;
    int idx, pair;
    logic [XLEN-1:0] ret, pfx, hnd;
    logic [SW-1:0] sv, ns;
    @(negedge clk);
    cause  = 6'(c);
    errc   = 32'h0840_0A50 | SW'(sub);
    state  = st;
    pc     = 64'h9000_0000_0000_1000 + XLEN'(c * 8 + sub);
    prefix = 64'hC0DE_1234_0000_0000 | (XLEN'(c) << 24) | 64'h8000_0000;
    req    = 1'b1;
    // reference model
    legal = (c <= 14) || (c >= 32 && c <= 37);
    idx   = (c == 6 && sub == 3) ? 15 : c;
    pair  = (c == 0 || c == 12) ? 1 : (c == 1) ? 2 : 0;
    ret   = (c == 5 || c == 6 || c == 7) ? pc - 64'd4 : pc;
    sv    = st;
    if (c == 2 || c == 3 || c == 6 || c == 7 || c == 10 || c == 11 || c == 12)
      sv = st & 32'h0000_FFFF;
    if (c == 3) sv = sv | errc;
    if (c == 6) sv = sv | (32'h1 << (20 - sub));
    ns = st & ~(32'h0004_0033);
    ns[0]  = st[16];
    ns[31] = st[30];
    if (pair == 2) begin ns[17] = 1'b0; ns[12] = 1'b0; end
    pfx = ns[31] ? prefix : {32'h0, prefix[31:0]};
    hnd = pfx | ((idx < 16) ? off_val(idx) : off_val(100 + idx - 32));
    @(negedge clk);
    req = 1'b0;
    if (legal) begin
      if (pair == 0) begin m_std_a = ret; m_std_s = sv; end
      if (pair >= 1) begin m_crit_a = ret; m_crit_s = sv; end
      if (pair == 2) begin m_mc_a = ret; m_mc_s = sv; end
      chk("R12 done", XLEN'(done), 1);
      chk("R4 no err", XLEN'(err), 0);
      chk("R1 R2 R3 R11 handler", new_pc, hnd);
      chk("R10 new state", XLEN'(new_st), XLEN'(ns));
      chk("R6 std we", XLEN'(std_we), XLEN'(pair == 0));
      chk("R6 crit we", XLEN'(crit_we), XLEN'(pair >= 1));
      chk("R7 mc we", XLEN'(mc_we), XLEN'(pair == 2));
      chk_pairs("R8 R9");
      @(negedge clk);
      chk("R12 done pulse", XLEN'(done), 0);
    end else begin
      chk("R4 err set", XLEN'(err), 1);
      chk("R4 no done", XLEN'(done), 0);
      chk_pairs("R4");
      // legal request while error pending must be ignored
      cause = 6'd4; errc = '0; pc = 64'h1234; state = 32'hFFFF_FFFF; req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      chk("R5 ignored done", XLEN'(done), 0);
      chk("R4 err sticky", XLEN'(err), 1);
      chk_pairs("R5");
      err_clr = 1'b1;
      @(negedge clk);
      err_clr = 1'b0;
      chk("R4 err cleared", XLEN'(err), 0);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 reset done", XLEN'(done), 0);
    chk("R12 reset err", XLEN'(err), 0);
    chk("R12 reset pc", new_pc, 0);
    chk("R12 reset state", XLEN'(new_st), 0);
    chk_pairs("R12 reset");
    rst_ni = 1'b1;
    for (int c = 0; c < 64; c++)
      for (int sub = 0; sub < 4; sub++) begin
        run_one(c, sub, 32'hFFFF_FFFF);
        run_one(c, sub, 32'h2A5A_5A5A ^ SW'(c << 8));
      end
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule